// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block is always powered and sits between the peripheral interrupt lines and a downstream interrupt controller. Every shared interrupt line goes through it to the controller after one register stage, and the enable bits have no effect on that path. Two fixed external lines are active-low. The block inverts them so that every line reaching the controller is active-high.

Each CPU has its own set of enable words, with one bit per interrupt line. A CPU that signals it is in a low-power state gets a registered wakeup request whenever one of its enabled lines is active. A mode bit chooses how requests are shared. In joint mode, a request from any CPU wakes all of them. In independent mode, each CPU wakes only from its own request. Software reads and writes the enable words and the mode bit through a small word-addressed register port.

Top module: `wkgen_top`

## Requirements
- R1: After reset, every enable word and the mode bit read as zero, and `irq_out` and `wake_req` are all low.
- R2: The enable word for CPU c and bank b is at byte address c*0x400 + b*4. Interrupt line n is bit n%32 of bank n>>5. A written word reads back unchanged on `bus_rdata` in the cycle after `bus_rd`. When no read is requested, `bus_rdata` is zero.
- R3: Any address that is not a configured enable word and not the mode register reads as zero, and a write to it changes no enable word and not the mode bit.
- R4: Every line except lines 7 and 119 appears on `irq_out` one cycle after `irq_in`, whatever the enable bits hold.
- R5: Lines 7 and 119 are active-low inputs. `irq_out` presents them inverted, one cycle later.
- R6: A line counts as active when its `irq_out` value would be 1. A CPU with `cpu_sleep` high raises a request when an active line has its enable bit set. A line whose enable bit is clear never causes a request.
- R7: The mode bit is bit 0 of byte address NUM_CPUS*0x400. When it is 1 (independent mode), `wake_req[c]` is exactly CPU c's own request, one cycle after the inputs.
- R8: When the mode bit is 0 (joint mode), all `wake_req` bits are set, one cycle after the inputs, if any CPU raises a request. Otherwise they are all clear.
- R9: `wake_req` stays high for as long as the enabled line stays active. It falls in the cycle after the line goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_BANKS*32 | Raw peripheral interrupt lines |
| irq_out | output | NUM_BANKS*32 | Registered, polarity-normalised lines to the downstream controller |
| cpu_sleep | input | NUM_CPUS | High while the CPU is in a low-power state |
| wake_req | output | NUM_CPUS | Registered wakeup request per CPU |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after bus_rd |

## Verification
The bench sweeps every one of the 128 lines in a four-bank, two-CPU build. For each line it checks the pass-through value and the wakeup with only that line's enable bit set. A design with the bit/bank mapping off by one, or with the wrong lines inverted, fails at a single line index. The bench also drives the neighbouring line while the original enable bit is still set, which catches a design that ignores the enables or aliases the banks. A version that forgets the sleep gating, or that mixes up the joint and independent modes, shows the wrong `wake_req` pattern. Addresses past the last bank, above the last CPU, and next to the mode register are read and written. This exposes decode that wraps around onto real storage.

// File: rtl/wkgen_pkg.sv
package wkgen_pkg;
  localparam int WORD_W      = 32;
  localparam int WORD_SHIFT  = 5;   // 32 lines per enable word
  localparam int CPU_SHIFT   = 10;  // 0x400 byte stride between CPU banks
  localparam int BANK_FIELD  = CPU_SHIFT - 2;

  function automatic int lines_for(input int banks);
    return banks * WORD_W;
  endfunction
endpackage

// File: rtl/wkgen_regfile.sv
module wkgen_regfile
  import wkgen_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 12
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       bus_wr,
  input  logic                                       bus_rd,
  input  logic [ADDR_W-1:0]                          bus_addr,
  input  logic [WORD_W-1:0]                          bus_wdata,
  output logic [WORD_W-1:0]                          bus_rdata,
  output logic [NUM_CPUS-1:0][lines_for(NUM_BANKS)-1:0] enables,
  output logic                                       mode_indep
);
  localparam int NUM_LINES = lines_for(NUM_BANKS);
  localparam int CPU_W     = ADDR_W - CPU_SHIFT;

  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_q;
  logic                               mode_q;
  logic [WORD_W-1:0]                  rdata_q;
  logic [WORD_W-1:0]                  rd_word;
  logic [CPU_W-1:0]                   cpu_f;
  logic [BANK_FIELD-1:0]              bank_f;
  logic                               hit_bank;
  logic                               hit_mode;

  assign cpu_f    = bus_addr[ADDR_W-1:CPU_SHIFT];
  assign bank_f   = bus_addr[CPU_SHIFT-1:2];
  assign hit_bank = (32'(cpu_f) < NUM_CPUS) && (32'(bank_f) < NUM_BANKS);
  assign hit_mode = (32'(cpu_f) == NUM_CPUS) && (bank_f == '0);

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (hit_bank && 32'(cpu_f) == c && 32'(bank_f) == b)
          rd_word = en_q[c][b*WORD_W +: WORD_W];
      end
    end
    if (hit_mode) rd_word = {{(WORD_W-1){1'b0}}, mode_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= 1'b0;
    end else if (bus_wr) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (hit_bank && 32'(cpu_f) == c && 32'(bank_f) == b)
            en_q[c][b*WORD_W +: WORD_W] <= bus_wdata;
        end
      end
      if (hit_mode) mode_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? rd_word : '0;
  end

  assign bus_rdata  = rdata_q;
  assign enables    = en_q;
  assign mode_indep = mode_q;

  // R3: writes that decode to nothing leave all storage untouched
  p_oob_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit_bank && !hit_mode) |=> ($stable(en_q) && $stable(mode_q)));

  // R2: read data is zero whenever no read was requested
  p_rdata_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R3: unmapped reads return zero
  p_oob_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit_bank && !hit_mode) |=> (bus_rdata == '0));
endmodule

// File: rtl/wkgen_polarity.sv
module wkgen_polarity #(
  parameter int NUM_LINES = 160,
  parameter int INV_A     = 7,
  parameter int INV_B     = 119
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] norm,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam logic [NUM_LINES-1:0] INV_MASK =
    (NUM_LINES'(1) << INV_A) | (NUM_LINES'(1) << INV_B);

  logic [NUM_LINES-1:0] out_q;

  assign norm = irq_in ^ INV_MASK;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= norm;
  end

  assign irq_out = out_q;

  // R5: the active-low lines arrive inverted one cycle later
  p_inv_line_a_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out[INV_A] == !$past(irq_in[INV_A])));
  p_inv_line_b_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out[INV_B] == !$past(irq_in[INV_B])));

  // R4: an ordinary line passes with the same polarity
  p_pass_line_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out[0] == $past(irq_in[0])));
endmodule

// File: rtl/wkgen_wake.sv
module wkgen_wake #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 160
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_LINES-1:0]               norm,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0] enables,
  input  logic [NUM_CPUS-1:0]                cpu_sleep,
  input  logic                               mode_indep,
  output logic [NUM_CPUS-1:0]                wake_req
);
  logic [NUM_CPUS-1:0] req;
  logic [NUM_CPUS-1:0] wake_q;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign req[c] = cpu_sleep[c] & (|(norm & enables[c]));

    // R7: an awake CPU in independent mode never gets a request
    p_awake_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (mode_indep && !cpu_sleep[c]) |=> !wake_req[c]);
  end

  always_ff @(posedge clk) begin
    if (rst)             wake_q <= '0;
    else if (mode_indep) wake_q <= req;
    else                 wake_q <= {NUM_CPUS{|req}};
  end

  assign wake_req = wake_q;

  // R8: in joint mode the outputs are all set or all clear
  p_joint_uniform_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_indep |=> ($countones(wake_req) == 0 || $countones(wake_req) == NUM_CPUS));

  // R6: with every enable clear there is no request
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (enables == '0) |=> (wake_req == '0));

  // R6: with no CPU asleep there is no request
  p_nosleep_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_sleep == '0) |=> (wake_req == '0));
endmodule

// File: rtl/wkgen_top.sv
module wkgen_top
  import wkgen_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 12,
  parameter int INV_A     = 7,
  parameter int INV_B     = 119
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [lines_for(NUM_BANKS)-1:0]   irq_in,
  output logic [lines_for(NUM_BANKS)-1:0]   irq_out,
  input  logic [NUM_CPUS-1:0]               cpu_sleep,
  output logic [NUM_CPUS-1:0]               wake_req,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [WORD_W-1:0]                 bus_wdata,
  output logic [WORD_W-1:0]                 bus_rdata
);
  localparam int NUM_LINES = lines_for(NUM_BANKS);

  logic [NUM_CPUS-1:0][NUM_LINES-1:0] enables;
  logic                               mode_indep;
  logic [NUM_LINES-1:0]               norm;

  wkgen_regfile #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .enables   (enables),
    .mode_indep(mode_indep)
  );

  wkgen_polarity #(
    .NUM_LINES(NUM_LINES),
    .INV_A    (INV_A),
    .INV_B    (INV_B)
  ) u_pol (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .norm   (norm),
    .irq_out(irq_out)
  );

  wkgen_wake #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_LINES(NUM_LINES)
  ) u_wake (
    .clk       (clk),
    .rst       (rst),
    .norm      (norm),
    .enables   (enables),
    .cpu_sleep (cpu_sleep),
    .mode_indep(mode_indep),
    .wake_req  (wake_req)
  );
endmodule

// File: tb/tb_wkgen_top.sv
module tb_wkgen_top;
  localparam int NC = 2;
  localparam int NB = 4;
  localparam int L  = NB * 32;
  localparam logic [L-1:0] IDLE = (L'(1) << 7) | (L'(1) << 119);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [L-1:0]  irq_in = IDLE;
  logic [L-1:0]  irq_out;
  logic [NC-1:0] cpu_sleep = '0;
  logic [NC-1:0] wake_req;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  wkgen_top #(.NUM_CPUS(NC), .NUM_BANKS(NB), .ADDR_W(12)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
    .cpu_sleep(cpu_sleep), .wake_req(wake_req),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [11:0] ea(input int c, input int b);
    return 12'(c * 1024 + b * 4);
  endfunction

  function automatic logic [31:0] pat(input int c, input int b);
    return 32'hA5C3_0000 ^ 32'(c << 12) ^ (32'(b) * 32'h0101_0101);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick; tick;
    rst = 1'b0;
    tick;
    // R1: reset state
    chk(irq_out == '0, "R1 irq_out", irq_out, '0);
    chk(wake_req == '0, "R1 wake_req", L'(wake_req), '0);
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) begin
        rd(ea(c, b), d);
        chk(d == 32'd0, "R1 enable word", L'(d), '0);
      end
    rd(12'h800, d);
    chk(d == 32'd0, "R1 mode", L'(d), '0);

    // R2: write every enable word then read all back
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) wr(ea(c, b), pat(c, b));
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) begin
        rd(ea(c, b), d);
        chk(d == pat(c, b), "R2 readback", L'(d), L'(pat(c, b)));
      end
    tick;
    chk(bus_rdata == 32'd0, "R2 idle rdata", L'(bus_rdata), '0);

    // R3: unmapped addresses
    wr(ea(0, NB), 32'hFFFF_FFFF);
    wr(ea(1, NB + 3), 32'hFFFF_FFFF);
    wr(12'hC00, 32'hFFFF_FFFF);
    wr(12'h804, 32'hFFFF_FFFF);
    rd(ea(0, NB), d);       chk(d == 0, "R3 read past banks", L'(d), '0);
    rd(12'hC00, d);         chk(d == 0, "R3 read past cpus", L'(d), '0);
    rd(12'h804, d);         chk(d == 0, "R3 read beside mode", L'(d), '0);
    rd(12'h800, d);         chk(d == 0, "R3 mode untouched", L'(d), '0);
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) begin
        rd(ea(c, b), d);
        chk(d == pat(c, b), "R3 enables untouched", L'(d), L'(pat(c, b)));
      end

    // R4 R5: pass-through sweep, enables hold arbitrary data
    irq_in = '0; tick;
    chk(irq_out == IDLE, "R5 all-low input", irq_out, IDLE);
    for (int n = 0; n < L; n++) begin
      irq_in = L'(1) << n;
      tick;
      chk(irq_out == ((L'(1) << n) ^ IDLE), (n == 7 || n == 119) ? "R5 inverted line" : "R4 pass line",
          irq_out, (L'(1) << n) ^ IDLE);
    end
    irq_in = IDLE; tick;
    chk(irq_out == '0, "R5 idle input", irq_out, '0);

    // clear enables, independent mode
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) wr(ea(c, b), 32'd0);
    wr(12'h800, 32'd1);
    rd(12'h800, d);
    chk(d == 32'd1, "R7 mode readback", L'(d), L'(1));

    // R6 R7: per-line wake sweep on CPU 0
    for (int n = 0; n < L; n++) begin
      wr(ea(0, n >> 5), 32'(1) << (n % 32));
      irq_in = IDLE ^ (L'(1) << n);
      cpu_sleep = 2'b11;
      tick;
      chk(wake_req == 2'b01, "R7 own cpu wakes", L'(wake_req), L'(2'b01));
      cpu_sleep = 2'b10;
      tick;
      chk(wake_req == 2'b00, "R6 awake cpu quiet", L'(wake_req), '0);
      cpu_sleep = 2'b11;
      irq_in = IDLE ^ (L'(1) << ((n + 1) % L));
      tick;
      chk(wake_req == 2'b00, "R6 disabled line quiet", L'(wake_req), '0);
      irq_in = IDLE; cpu_sleep = 2'b00;
      wr(ea(0, n >> 5), 32'd0);
    end

    // R7: CPU 1 alone, line 7 driven low
    wr(ea(1, 0), 32'h0000_0080);
    irq_in = IDLE ^ (L'(1) << 7);
    cpu_sleep = 2'b11;
    tick;
    chk(wake_req == 2'b10, "R7 cpu1 only", L'(wake_req), L'(2'b10));
    irq_in = IDLE; cpu_sleep = 2'b00;
    wr(ea(1, 0), 32'd0);

    // R8: joint mode, CPU 1 enables line 119 (bank 3 bit 23)
    wr(12'h800, 32'd0);
    wr(ea(1, 3), 32'h0080_0000);
    irq_in = IDLE ^ (L'(1) << 119);
    cpu_sleep = 2'b10;
    tick;
    chk(wake_req == 2'b11, "R8 joint wakes all", L'(wake_req), L'(2'b11));
    // R9: request held while line stays active
    for (int k = 0; k < 5; k++) begin
      tick;
      chk(wake_req == 2'b11, "R9 held", L'(wake_req), L'(2'b11));
    end
    irq_in = IDLE;
    tick;
    chk(wake_req == 2'b00, "R9 released", L'(wake_req), '0);
    irq_in = IDLE ^ (L'(1) << 119);
    cpu_sleep = 2'b01;
    tick;
    chk(wake_req == 2'b00, "R8 no sleeper with enable", L'(wake_req), '0);
    cpu_sleep = 2'b00;
    tick;
    chk(wake_req == 2'b00, "R8 none asleep", L'(wake_req), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule